// File: doc/BRIEF.md
# Character Attribute Pixel Combiner

This block turns one 8-dot row of a character cell into the 8 pixels that are shown on screen. On each valid cycle it takes three bytes: the font row for the current raster, the attribute byte for the character, and a graphics byte. It then applies the character's attribute effects in a fixed order. Blanking to white or to black comes first, then blinking, then reverse video. After that it can OR the graphics byte into the text. Last, it inverts the row where the cursor sits, but only on the raster lines the cursor covers.

A pixel value of 1 is a dark dot and 0 is a white dot. A frame counter advances on each frame tick and supplies the blink phases. Characters blink with a 32-frame period. The cursor blinks with either a 16-frame or a 32-frame period, chosen by a select input. Mode inputs switch attribute handling off, switch blinking off, and select the OR overlay. The font lookup and the memory addressing sit upstream and are not part of this block.

Top module: `char_attr_pixel_mixer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_valid` and `pix_out` become 0 and the frame counter becomes 0.
- R2: When `attr_en` is 0, the attribute byte has no effect. The row before the overlay is `font_row`.
- R3: The attribute bits are: bit 2 blanks to white and sets the row to 8'h00; bit 3 blanks to black and sets the row to 8'hFF. When both bits are set, bit 2 wins. Blanking replaces the font row.
- R4: Attribute bit 1 sets blink. The row after blanking is forced to 8'h00 when `blink_en` is 1 and bit 4 of the frame counter is 1. Otherwise bit 1 has no effect.
- R5: Attribute bit 0 sets reverse. It inverts the row after the blanking and blink steps.
- R6: When `or_mode` is 1, the row is bitwise ORed with `gfx_row` after the attribute steps.
- R7: The row is inverted as the last step when all of these hold: `cursor_on` is 1, `cursor_hit` is 1, `cur_start` <= `raster` <= `cur_end`, and the cursor is visible.
- R8: The cursor is hidden when `blink_en` is 1 and the selected frame counter bit is 1. That bit is bit 3 when `cur_rate_sel` is 0 and bit 4 when it is 1. When `blink_en` is 0, the cursor is always visible.
- R9: `pix_out` shows the result one clock after the inputs are sampled with `in_valid` high. `pix_valid` equals `in_valid` delayed by one clock. `pix_out` holds its value after a cycle with `in_valid` low.
- R10: The frame counter is 5 bits wide. It adds one on each clock edge where `frame_tick` is 1 and wraps from 31 to 0. The blink phase inputs to the pixel logic use the counter value from before that edge's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input row is valid this cycle |
| font_row | input | 8 | Character dot row (low byte of memory word) |
| attr_byte | input | 8 | Attribute code (high byte of memory word) |
| gfx_row | input | 8 | Graphics byte for the OR overlay |
| attr_en | input | 1 | Enables attribute processing |
| blink_en | input | 1 | Enables character and cursor blinking |
| or_mode | input | 1 | Selects the OR overlay of graphics on text |
| cursor_on | input | 1 | Cursor on/off switch |
| cursor_hit | input | 1 | The current character is at the cursor position |
| raster | input | 5 | Current raster line in the cell |
| cur_start | input | 5 | First raster line of the cursor |
| cur_end | input | 5 | Last raster line of the cursor |
| cur_rate_sel | input | 1 | Cursor blink period: 0 = 16 frames, 1 = 32 frames |
| frame_tick | input | 1 | One pulse per frame |
| pix_out | output | 8 | Output pixel row, 1 = dark dot |
| pix_valid | output | 1 | `pix_out` holds a new row |

## Verification
The only internal state is the frame counter, so a fault there shows up as blink phases that are wrong. A counter that skips, sticks or fails to wrap makes characters blank, or the cursor vanish, on the wrong frames. With 16-frame cursor blink this shows within 8 frame ticks of the fault, and for characters within 16. A wrong step order, or a bad enable gate, shows on the very next valid row: one cycle after the input that exercises it.

// File: rtl/cap_pkg.sv
// Package for the character attribute pixel combiner.
// Holds the shared widths and the attribute bit positions.
// Assumes an 8-dot cell and an attribute byte in which only
// the low four bits carry meaning.
package cap_pkg;
    localparam int DOT_W    = 8;
    localparam int RASTER_W = 5;
    localparam int FRAME_W  = 5;

    localparam int ATTR_REV     = 0;
    localparam int ATTR_BLINK   = 1;
    localparam int ATTR_BLANK_W = 2;
    localparam int ATTR_BLANK_B = 3;

    typedef struct packed {
        logic blank_black;
        logic blank_white;
        logic blink;
        logic reverse;
    } attr_t;
endpackage

// File: rtl/cap_blink_timer.sv
// Frame counter and blink phase source.
// Counts frame ticks and wraps at 2**FRAME_W. It gives out the
// character blink phase (top bit) and the cursor blink phase
// (top bit, or the bit below it for the faster rate).
// Assumes FRAME_W >= 2.
module cap_blink_timer #(
    parameter int FRAME_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic rate_sel,
    output logic char_off,
    output logic cur_off
);
    localparam int SLOW_BIT = FRAME_W - 1;
    localparam int FAST_BIT = FRAME_W - 2;

    logic [FRAME_W-1:0] frame_cnt;

    // Advance the frame count once per tick; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_cnt <= '0;
        else if (frame_tick)
            frame_cnt <= frame_cnt + 1'b1;
    end

    // Choose the phase bits the pixel logic uses.
    always_comb begin
        char_off = frame_cnt[SLOW_BIT];
        cur_off  = rate_sel ? frame_cnt[SLOW_BIT] : frame_cnt[FAST_BIT];
    end

    // Check: a tick adds exactly one (R10).
    p_tick_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> frame_cnt == $past(frame_cnt) + 1'b1);
    // Check: without a tick the count holds (R10).
    p_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(frame_cnt));
endmodule

// File: rtl/cap_attr_stage.sv
// Attribute stage: applies blanking, then blink, then reverse to
// one font row. When attr_en is low the row passes through unchanged.
// Pure combinational logic. The blink phase comes from outside.
module cap_attr_stage
    import cap_pkg::*;
#(
    parameter int W = DOT_W
) (
    input  logic [W-1:0] font_row,
    input  attr_t        attr,
    input  logic         attr_en,
    input  logic         blink_en,
    input  logic         char_off,
    output logic [W-1:0] row_out
);
    logic [W-1:0] after_blank;
    logic [W-1:0] after_blink;

    // Blanking first: white wins over black.
    always_comb begin
        if (attr_en && attr.blank_white)
            after_blank = '0;
        else if (attr_en && attr.blank_black)
            after_blank = '1;
        else
            after_blank = font_row;
    end

    // Blink blanks the row during the off half of the period.
    always_comb begin
        if (attr_en && attr.blink && blink_en && char_off)
            after_blink = '0;
        else
            after_blink = after_blank;
    end

    // Reverse video inverts the result of the steps above.
    always_comb begin
        row_out = (attr_en && attr.reverse) ? ~after_blink : after_blink;
    end
endmodule

// File: rtl/cap_cursor_stage.sv
// Overlay stage: ORs in graphics when selected, then inverts the
// row under a visible cursor that lies in its raster range.
// Pure combinational logic. Assumes cur_start <= cur_end for
// a non-empty cursor.
module cap_cursor_stage #(
    parameter int W  = 8,
    parameter int RW = 5
) (
    input  logic [W-1:0]  row_in,
    input  logic [W-1:0]  gfx_row,
    input  logic          or_mode,
    input  logic          cursor_on,
    input  logic          cursor_hit,
    input  logic [RW-1:0] raster,
    input  logic [RW-1:0] cur_start,
    input  logic [RW-1:0] cur_end,
    input  logic          blink_en,
    input  logic          cur_off,
    output logic [W-1:0]  row_out
);
    logic [W-1:0] merged;
    logic         in_range;
    logic         invert;

    // Superimpose the graphics byte on the text row.
    always_comb begin
        merged = or_mode ? (row_in | gfx_row) : row_in;
    end

    // Decide whether the cursor covers this row.
    always_comb begin
        in_range = (raster >= cur_start) && (raster <= cur_end);
        invert   = cursor_on && cursor_hit && in_range && !(blink_en && cur_off);
    end

    // Invert under the cursor as the last step.
    always_comb begin
        row_out = invert ? ~merged : merged;
    end
endmodule

// File: rtl/char_attr_pixel_mixer.sv
// Character attribute pixel combiner, top level.
// Combines font, attribute and graphics bytes into one output row
// with one cycle of latency. Pixel 1 = dark dot.
// Assumes the inputs are stable around the clock edge and reset
// is synchronous and active low.
module char_attr_pixel_mixer
    import cap_pkg::*;
#(
    parameter int W       = DOT_W,
    parameter int RW      = RASTER_W,
    parameter int FW      = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  font_row,
    input  logic [7:0]    attr_byte,
    input  logic [W-1:0]  gfx_row,
    input  logic          attr_en,
    input  logic          blink_en,
    input  logic          or_mode,
    input  logic          cursor_on,
    input  logic          cursor_hit,
    input  logic [RW-1:0] raster,
    input  logic [RW-1:0] cur_start,
    input  logic [RW-1:0] cur_end,
    input  logic          cur_rate_sel,
    input  logic          frame_tick,
    output logic [W-1:0]  pix_out,
    output logic          pix_valid
);
    attr_t        attr;
    logic         char_off;
    logic         cur_off;
    logic [W-1:0] attr_row;
    logic [W-1:0] final_row;

    // Unpack the attribute bits used by this block.
    always_comb begin
        attr.reverse     = attr_byte[ATTR_REV];
        attr.blink       = attr_byte[ATTR_BLINK];
        attr.blank_white = attr_byte[ATTR_BLANK_W];
        attr.blank_black = attr_byte[ATTR_BLANK_B];
    end

    cap_blink_timer #(.FRAME_W(FW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .rate_sel   (cur_rate_sel),
        .char_off   (char_off),
        .cur_off    (cur_off)
    );

    cap_attr_stage #(.W(W)) u_attr (
        .font_row (font_row),
        .attr     (attr),
        .attr_en  (attr_en),
        .blink_en (blink_en),
        .char_off (char_off),
        .row_out  (attr_row)
    );

    cap_cursor_stage #(.W(W), .RW(RW)) u_cursor (
        .row_in     (attr_row),
        .gfx_row    (gfx_row),
        .or_mode    (or_mode),
        .cursor_on  (cursor_on),
        .cursor_hit (cursor_hit),
        .raster     (raster),
        .cur_start  (cur_start),
        .cur_end    (cur_end),
        .blink_en   (blink_en),
        .cur_off    (cur_off),
        .row_out    (final_row)
    );

    // Register the row on valid inputs; the strobe follows in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out   <= '0;
            pix_valid <= 1'b0;
        end else begin
            pix_valid <= in_valid;
            if (in_valid)
                pix_out <= final_row;
        end
    end

    // Check: the strobe is in_valid one cycle later (R9).
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> pix_valid);
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !pix_valid);
    // Check: the output holds after an idle cycle (R9).
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pix_out));
    // Check: the font passes straight through with every effect off (R2).
    p_plain_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !attr_en && !or_mode && !cursor_on) |=> pix_out == $past(font_row));
    // Check: white blanking shows a white row when nothing follows it (R3).
    p_white_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && attr_en && attr_byte[2] && !attr_byte[0] && !or_mode && !cursor_on)
            |=> pix_out == '0);
endmodule

// File: tb/char_attr_pixel_mixer_tb.sv
module char_attr_pixel_mixer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] font_row = '0, attr_byte = '0, gfx_row = '0;
    logic       attr_en = 1'b0, blink_en = 1'b0, or_mode = 1'b0;
    logic       cursor_on = 1'b0, cursor_hit = 1'b0;
    logic [4:0] raster = '0, cur_start = '0, cur_end = '0;
    logic       cur_rate_sel = 1'b0, frame_tick = 1'b0;
    logic [7:0] pix_out;
    logic       pix_valid;

    int tests = 0;
    int fails = 0;
    logic [4:0] mcnt = '0;
    logic [7:0] last_out = '0;

    always #2 clk = ~clk;

    char_attr_pixel_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .font_row(font_row),
        .attr_byte(attr_byte), .gfx_row(gfx_row), .attr_en(attr_en),
        .blink_en(blink_en), .or_mode(or_mode), .cursor_on(cursor_on),
        .cursor_hit(cursor_hit), .raster(raster), .cur_start(cur_start),
        .cur_end(cur_end), .cur_rate_sel(cur_rate_sel), .frame_tick(frame_tick),
        .pix_out(pix_out), .pix_valid(pix_valid)
    );

    // Reference model written from the requirements.
    function automatic logic [7:0] model(input logic [4:0] cnt);
        logic [7:0] p;
        logic       hide;
        p = font_row;
        if (attr_en) begin
            if (attr_byte[2]) p = 8'h00;            // R3
            else if (attr_byte[3]) p = 8'hFF;
            if (attr_byte[1] && blink_en && cnt[4]) p = 8'h00; // R4
            if (attr_byte[0]) p = ~p;               // R5
        end
        if (or_mode) p = p | gfx_row;               // R6
        hide = blink_en && (cur_rate_sel ? cnt[4] : cnt[3]); // R8
        if (cursor_on && cursor_hit && raster >= cur_start && raster <= cur_end && !hide)
            p = ~p;                                 // R7
        return p;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // One clock: inputs set before, compare after at the falling edge.
    task automatic cycle(input string req);
        logic [7:0] e;
        logic       v;
        e = model(mcnt);
        v = in_valid;
        @(posedge clk);
        if (frame_tick) mcnt = mcnt + 5'd1;         // R10
        @(negedge clk);
        check("R9 valid", {7'd0, pix_valid}, {7'd0, v});
        if (v) last_out = e;
        check(req, pix_out, last_out);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0; frame_tick = 1'b1;
            cycle("R10 tick");
        end
        frame_tick = 1'b0;
    endtask

    task automatic clear_modes();
        attr_en = 0; blink_en = 0; or_mode = 0; cursor_on = 0; cursor_hit = 0;
        attr_byte = 0; gfx_row = 0; frame_tick = 0; in_valid = 1;
    endtask

    initial begin
        #400000;
        fails++; tests++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1 reset out", pix_out, 8'h00);
        check("R1 reset valid", {7'd0, pix_valid}, 8'h00);
        rst_n = 1'b1;

        // R2: attribute ignored when disabled
        clear_modes(); font_row = 8'h3C; attr_byte = 8'h0F;
        cycle("R2 attr off");
        // R3: white, black, white beats black
        attr_en = 1; attr_byte = 8'h04; cycle("R3 white");
        attr_byte = 8'h08; cycle("R3 black");
        attr_byte = 8'h0C; cycle("R3 both");
        // R5: reverse alone and over black blanking
        attr_byte = 8'h01; cycle("R5 reverse");
        attr_byte = 8'h09; cycle("R5 reverse black");
        // R6: OR overlay
        attr_byte = 8'h00; or_mode = 1; gfx_row = 8'h81; cycle("R6 or");
        or_mode = 0;
        // R9: hold on idle
        in_valid = 0; font_row = 8'hAA; cycle("R9 hold");
        in_valid = 1;
        // R4: blink off phase at count 16, blink_en gating
        ticks(16);
        check("R10 count 16", {3'd0, mcnt}, 8'd16);
        in_valid = 1; blink_en = 1; attr_byte = 8'h02; font_row = 8'h7E;
        cycle("R4 blink off");
        blink_en = 0; cycle("R4 blink disabled");
        // R7/R8: cursor in range, fast rate hidden at bit3 (count 16 -> bit3=0 visible)
        attr_byte = 0; cursor_on = 1; cursor_hit = 1; cur_start = 5'd2; cur_end = 5'd4;
        raster = 5'd4; blink_en = 1; cur_rate_sel = 0; cycle("R7 cursor end line");
        raster = 5'd5; cycle("R7 cursor outside");
        raster = 5'd2; cur_rate_sel = 1; cycle("R8 slow hidden");
        ticks(8);
        in_valid = 1; cur_rate_sel = 0; cycle("R8 fast hidden");
        blink_en = 0; cycle("R8 blink off shows");
        // R10: wrap back to 0
        ticks(8);
        in_valid = 1; blink_en = 1; attr_byte = 8'h02; cursor_on = 0;
        cycle("R10 wrap blink on");
        check("R10 count wrap", {3'd0, mcnt}, 8'd0);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            in_valid   = ($urandom_range(0, 7) != 0);
            font_row   = 8'($urandom); attr_byte = 8'($urandom); gfx_row = 8'($urandom);
            attr_en    = 1'($urandom); blink_en = 1'($urandom); or_mode = 1'($urandom);
            cursor_on  = 1'($urandom); cursor_hit = 1'($urandom);
            raster     = 5'($urandom); cur_start = 5'($urandom_range(0, 15));
            cur_end    = 5'($urandom_range(8, 31)); cur_rate_sel = 1'($urandom);
            frame_tick = ($urandom_range(0, 3) == 0);
            cycle("R2-R9 random");
        end

        // Reset mid-run clears state
        rst_n = 0; @(posedge clk); mcnt = '0; last_out = '0; @(negedge clk);
        check("R1 rerun out", pix_out, 8'h00);
        rst_n = 1; clear_modes(); blink_en = 1; attr_en = 1; attr_byte = 8'h02; font_row = 8'hF0;
        cycle("R1 counter cleared");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule